// File: doc/BRIEF.md
# Unsigned Byte Load Unit with Precise Faults

This unit executes one instruction of a 32-bit load/store pipeline: an unsigned byte load. It decodes the instruction word and adds the two source operand values to form the effective address. It then samples the translation-miss and protection-violation flags that an external memory-management stage reports for that address. If no fault applies, it reads a 32-bit word from a simple data memory port, picks the addressed byte lane and writes the byte, zero-extended, to the destination register. If a fault applies, it does not touch the destination register. It reports the fault cause and the new values of the four mode bits, so that the processor status and exception status registers can be updated.

The instruction word carries a flag that reverses the byte order of the access relative to the configured endianness. The flag takes effect only when the reorder parameter is set. A speed build finishes the load one clock after issue. An area build stages the request for one cycle, finishes two clocks after issue, and raises `busy` during the extra cycle so that the issue logic holds the next instruction.

Top module: `bload_unit`

## Requirements
- R1: An instruction is accepted only when `issue_valid` is high, `instr[31:26]` is 6'b110000, `instr[10]` is 0 and `instr[8:0]` is 0. Any other word causes no memory read, no register write and no fault report. The destination index is `instr[25:21]`, the source indices are `instr[20:16]` and `instr[15:11]`, and the byte-reverse flag is `instr[9]`.
- R2: During an accepted load, `mem_addr` is the sum of `opnd_a` and `opnd_b` modulo 2^32, and `mem_rd_en` is high.
- R3: `rd_data` holds the selected byte in bits [7:0], with bits [31:8] zero. In the big-endian build, address offset 0 selects `mem_rdata[31:24]` and offset 3 selects `mem_rdata[7:0]`.
- R4: When REORDER_EN is 1 and `instr[9]` is 1, the two low address bits are inverted before the byte is selected. When REORDER_EN is 0, `instr[9]` has no effect.
- R5: When `cur_vm` and `xlat_miss` are both 1, the unit reports a fault with code 5'b10010 and leaves `exc_diz_set` low.
- R6: When there is no translation fault, and `prot_viol`, `cur_um` and `cur_vm` are all 1, the unit reports a fault with code 5'b10000 and raises `exc_diz_set`.
- R7: The translation check takes priority over the protection check. `xlat_miss` is ignored while `cur_vm` is 0, and `prot_viol` is ignored unless both mode bits are 1.
- R8: With every fault report, `msr_ums_nx` equals `cur_um`, `msr_vms_nx` equals `cur_vm`, and `msr_um_nx` and `msr_vm_nx` are 0.
- R9: A faulting load raises `exc_valid` for one cycle. In that load, `mem_rd_en` and `rd_we` stay low and `rd_idx`/`rd_data` stay zero.
- R10: With AREA_OPT = 0, the results are visible one clock after the issue edge, and back-to-back issues produce results in consecutive cycles.
- R11: With AREA_OPT = 1, the results are visible two clocks after the issue edge. `busy` is high for exactly the one cycle after acceptance, and an issue during that cycle is ignored.
- R12: While `rst_n` is low, and right after it is released, `rd_we`, `exc_valid`, `busy` and all result fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction offered this cycle |
| instr | input | 32 | Instruction word |
| opnd_a | input | 32 | First source operand value |
| opnd_b | input | 32 | Second source operand value |
| cur_um | input | 1 | Current user-mode bit |
| cur_vm | input | 1 | Current virtual-mode bit |
| xlat_miss | input | 1 | Translation miss for the access |
| prot_viol | input | 1 | Protection zone forbids the access |
| busy | output | 1 | Extra cycle of the area build in progress |
| src_a_idx | output | 5 | First source register index |
| src_b_idx | output | 5 | Second source register index |
| mem_rd_en | output | 1 | Data memory read strobe |
| mem_addr | output | 32 | Byte address of the read |
| mem_rdata | input | 32 | Word returned by memory in the same cycle |
| rd_we | output | 1 | Destination register write enable |
| rd_idx | output | 5 | Destination register index |
| rd_data | output | 32 | Zero-extended loaded byte |
| exc_valid | output | 1 | Fault reported this cycle |
| exc_code | output | 5 | Fault cause code |
| exc_diz_set | output | 1 | Set the zone-protection flag |
| msr_um_nx | output | 1 | New user-mode bit |
| msr_vm_nx | output | 1 | New virtual-mode bit |
| msr_ums_nx | output | 1 | Saved user-mode bit |
| msr_vms_nx | output | 1 | Saved virtual-mode bit |

## Verification
The memory strobe and address are combinational from the issue cycle in the speed build. The bench checks them a small delay after it drives the inputs. Every registered result is due one edge after issue in the speed build and two edges after issue in the area build. The bench therefore drives on falling edges and compares one and two falling edges later, where each output has settled. The `busy` flag is checked at the first of those two points. The back-to-back directed test checks that a second issue shows up in the speed build one cycle behind the first and is dropped by the area build.

// File: rtl/bload_pkg.sv
package bload_pkg;
  localparam int XLEN     = 32;
  localparam int BYTE_W   = 8;
  localparam int BYTES    = XLEN / BYTE_W;
  localparam int OFF_W    = $clog2(BYTES);
  localparam int RIDX_W   = 5;
  localparam int CODE_W   = 5;

  localparam logic [5:0]        OPC_LOAD_BYTE = 6'b110000;
  localparam logic [CODE_W-1:0] CODE_NONE     = 5'b00000;
  localparam logic [CODE_W-1:0] CODE_DSTORE   = 5'b10000;
  localparam logic [CODE_W-1:0] CODE_DXLAT    = 5'b10010;
  localparam logic [OFF_W-1:0]  LANE_TOP      = OFF_W'(BYTES - 1);

  typedef struct packed {
    logic              legal;
    logic              rev;
    logic [RIDX_W-1:0] rd;
    logic [RIDX_W-1:0] ra;
    logic [RIDX_W-1:0] rb;
  } dec_t;

  typedef struct packed {
    logic              valid;
    logic [CODE_W-1:0] code;
    logic              diz;
    logic              um;
    logic              vm;
    logic              ums;
    logic              vms;
  } exc_t;

  function automatic logic [XLEN-1:0] ea_sum(input logic [XLEN-1:0] a,
                                             input logic [XLEN-1:0] b);
    return a + b;
  endfunction

  // Offset after optional reversal, then mapped to a physical lane
  // (lane k = bits [8k+7:8k]).
  function automatic logic [OFF_W-1:0] lane_index(input logic [OFF_W-1:0] off,
                                                  input logic flip,
                                                  input logic big);
    logic [OFF_W-1:0] o;
    o = off ^ {OFF_W{flip}};
    return big ? (LANE_TOP - o) : o;
  endfunction
endpackage

// File: rtl/bload_decode.sv
module bload_decode
  import bload_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output dec_t            dec
);
  logic opc_hit;
  logic pad_zero;

  assign opc_hit  = (instr[31:26] == OPC_LOAD_BYTE);
  assign pad_zero = (instr[10] == 1'b0) && (instr[8:0] == 9'd0);

  always_comb begin
    dec.legal = opc_hit && pad_zero;
    dec.rev   = instr[9];
    dec.rd    = instr[25:21];
    dec.ra    = instr[20:16];
    dec.rb    = instr[15:11];
  end
endmodule

// File: rtl/bload_fault.sv
module bload_fault
  import bload_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic um,
  input  logic vm,
  input  logic miss,
  input  logic prot,
  output logic fault,
  output exc_t exc
);
  logic miss_hit;
  logic prot_hit;

  assign miss_hit = go && vm && miss;
  assign prot_hit = go && !miss_hit && um && vm && prot;
  assign fault    = miss_hit || prot_hit;

  always_comb begin
    exc.valid = fault;
    exc.code  = miss_hit ? CODE_DXLAT : (prot_hit ? CODE_DSTORE : CODE_NONE);
    exc.diz   = prot_hit;
    exc.um    = 1'b0;
    exc.vm    = 1'b0;
    exc.ums   = fault && um;
    exc.vms   = fault && vm;
  end

  // R7: a translation miss always wins over a protection hit
  p_xlat_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && vm && miss) |-> (exc.code == CODE_DXLAT) && !exc.diz);

  // R6: the zone flag is only set for user accesses in virtual mode
  p_diz_user_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exc.diz |-> (um && vm && prot));
endmodule

// File: rtl/bload_lane.sv
module bload_lane
  import bload_pkg::*;
#(
  parameter bit REORDER_EN = 1'b1,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic [XLEN-1:0]  word,
  input  logic [OFF_W-1:0] off,
  input  logic             rev,
  output logic [XLEN-1:0]  value
);
  logic [BYTE_W-1:0] lanes [BYTES];
  logic [OFF_W-1:0]  sel;
  logic              flip;

  for (genvar i = 0; i < BYTES; i++) begin : g_lane
    assign lanes[i] = word[BYTE_W*i +: BYTE_W];
  end

  if (REORDER_EN) begin : g_reorder
    assign flip = rev;
  end else begin : g_fixed
    assign flip = 1'b0;
  end

  assign sel   = lane_index(off, flip, BIG_ENDIAN);
  assign value = {{(XLEN-BYTE_W){1'b0}}, lanes[sel]};
endmodule

// File: rtl/bload_unit.sv
module bload_unit
  import bload_pkg::*;
#(
  parameter bit AREA_OPT   = 1'b0,
  parameter bit REORDER_EN = 1'b1,
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  input  logic [XLEN-1:0]   instr,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic              cur_um,
  input  logic              cur_vm,
  input  logic              xlat_miss,
  input  logic              prot_viol,
  output logic              busy,
  output logic [RIDX_W-1:0] src_a_idx,
  output logic [RIDX_W-1:0] src_b_idx,
  output logic              mem_rd_en,
  output logic [XLEN-1:0]   mem_addr,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              rd_we,
  output logic [RIDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]   rd_data,
  output logic              exc_valid,
  output logic [CODE_W-1:0] exc_code,
  output logic              exc_diz_set,
  output logic              msr_um_nx,
  output logic              msr_vm_nx,
  output logic              msr_ums_nx,
  output logic              msr_vms_nx
);
  dec_t              dec;
  logic              acc;
  logic [XLEN-1:0]   ea_now;
  logic              st_valid;
  logic              st_rev;
  logic [RIDX_W-1:0] st_rd;
  logic [XLEN-1:0]   st_ea;
  logic              st_um;
  logic              st_vm;
  logic              st_miss;
  logic              st_prot;
  logic              fault;
  logic              load_ok;
  exc_t              exc;
  logic [XLEN-1:0]   lane_val;

  bload_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign src_a_idx = dec.ra;
  assign src_b_idx = dec.rb;
  assign ea_now    = ea_sum(opnd_a, opnd_b);

  if (AREA_OPT) begin : g_two_cycle
    assign acc  = issue_valid && dec.legal && !st_valid;
    assign busy = st_valid;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_valid <= 1'b0;
        st_rev   <= 1'b0;
        st_rd    <= '0;
        st_ea    <= '0;
        st_um    <= 1'b0;
        st_vm    <= 1'b0;
        st_miss  <= 1'b0;
        st_prot  <= 1'b0;
      end else begin
        st_valid <= acc;
        if (acc) begin
          st_rev  <= dec.rev;
          st_rd   <= dec.rd;
          st_ea   <= ea_now;
          st_um   <= cur_um;
          st_vm   <= cur_vm;
          st_miss <= xlat_miss;
          st_prot <= prot_viol;
        end
      end
    end

    // R11: the stall lasts exactly one cycle per accepted load
    p_busy_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);
    // R11: acceptance is followed by the stall cycle
    p_accept_stalls_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && dec.legal && !busy) |=> busy);
  end else begin : g_one_cycle
    assign acc      = issue_valid && dec.legal;
    assign busy     = 1'b0;
    assign st_valid = acc;
    assign st_rev   = dec.rev;
    assign st_rd    = dec.rd;
    assign st_ea    = ea_now;
    assign st_um    = cur_um;
    assign st_vm    = cur_vm;
    assign st_miss  = xlat_miss;
    assign st_prot  = prot_viol;
  end

  bload_fault u_fault (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (st_valid),
    .um    (st_um),
    .vm    (st_vm),
    .miss  (st_miss),
    .prot  (st_prot),
    .fault (fault),
    .exc   (exc)
  );

  assign load_ok   = st_valid && !fault;
  assign mem_rd_en = load_ok;
  assign mem_addr  = st_ea;

  bload_lane #(
    .REORDER_EN (REORDER_EN),
    .BIG_ENDIAN (BIG_ENDIAN)
  ) u_lane (
    .word  (mem_rdata),
    .off   (st_ea[OFF_W-1:0]),
    .rev   (st_rev),
    .value (lane_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_we       <= 1'b0;
      rd_idx      <= '0;
      rd_data     <= '0;
      exc_valid   <= 1'b0;
      exc_code    <= CODE_NONE;
      exc_diz_set <= 1'b0;
      msr_um_nx   <= 1'b0;
      msr_vm_nx   <= 1'b0;
      msr_ums_nx  <= 1'b0;
      msr_vms_nx  <= 1'b0;
    end else begin
      rd_we       <= load_ok;
      rd_idx      <= load_ok ? st_rd : '0;
      rd_data     <= load_ok ? lane_val : '0;
      exc_valid   <= exc.valid;
      exc_code    <= exc.code;
      exc_diz_set <= exc.diz;
      msr_um_nx   <= exc.um;
      msr_vm_nx   <= exc.vm;
      msr_ums_nx  <= exc.ums;
      msr_vms_nx  <= exc.vms;
    end
  end

  // R9: a load either writes the register or reports a fault, never both
  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_we && exc_valid));
  // R9: a fault in the final stage suppresses the write on the next edge
  p_fault_blocks_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && fault) |=> (exc_valid && !rd_we));
  // R3: only the low byte of the written value may be nonzero
  p_zero_extend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_we |-> (rd_data[XLEN-1:BYTE_W] == '0));
  // R10: a clean final stage writes its destination one edge later
  p_write_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !fault) |=> (rd_we && (rd_idx == $past(st_rd))));
  // R8: the live mode bits come out cleared with every fault
  p_modes_cleared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (!msr_um_nx && !msr_vm_nx));
endmodule

// File: tb/bload_unit_test.sv
module bload_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] instr;
    logic [31:0] a;
    logic [31:0] b;
    logic        um;
    logic        vm;
    logic        miss;
    logic        prot;
  } vec_t;

  function automatic logic [31:0] mk(input int rd, input int ra, input int rb, input bit r);
    return {6'b110000, 5'(rd), 5'(ra), 5'(rb), 1'b0, r, 9'd0};
  endfunction

  localparam vec_t VEC [NVEC] = '{
    '{4'd3,  mk(3, 1, 2, 0),  32'h0000_0100, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd3,  mk(4, 5, 6, 0),  32'h0000_0200, 32'h1,          1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd2,  mk(5, 7, 8, 0),  32'hFFFF_FFFF, 32'h3,          1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd4,  mk(6, 1, 1, 1),  32'h0000_0300, 32'h1,          1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd4,  mk(31, 2, 3, 1), 32'h0000_0403, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd5,  mk(7, 2, 3, 0),  32'h0000_0010, 32'h0,          1'b0, 1'b1, 1'b1, 1'b0},
    '{4'd7,  mk(8, 2, 3, 0),  32'h0000_0020, 32'h2,          1'b0, 1'b0, 1'b1, 1'b0},
    '{4'd6,  mk(9, 2, 3, 0),  32'h0000_0030, 32'h0,          1'b1, 1'b1, 1'b0, 1'b1},
    '{4'd7,  mk(10, 2, 3, 0), 32'h0000_0040, 32'h1,          1'b0, 1'b1, 1'b0, 1'b1},
    '{4'd7,  mk(11, 2, 3, 0), 32'h0000_0050, 32'h0,          1'b1, 1'b1, 1'b1, 1'b1},
    '{4'd1,  32'hC400_0000,   32'h0000_0060, 32'h0,          1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd1,  mk(12, 1, 1, 0) | 32'h400, 32'h70, 32'h0,       1'b0, 1'b0, 1'b0, 1'b0},
    '{4'd7,  mk(13, 4, 4, 0), 32'h0000_0080, 32'h2,          1'b1, 1'b0, 1'b0, 1'b1},
    '{4'd3,  mk(14, 4, 4, 0), 32'h0000_007C, 32'h3,          1'b1, 1'b1, 1'b0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [31:0] instr = '0, opnd_a = '0, opnd_b = '0;
  logic        cur_um = 1'b0, cur_vm = 1'b0, xlat_miss = 1'b0, prot_viol = 1'b0;

  logic        f_busy, f_rd_en, f_we, f_exc, f_diz, f_um, f_vm, f_ums, f_vms;
  logic [4:0]  f_sa, f_sb, f_idx, f_code;
  logic [31:0] f_addr, f_rdata, f_data;
  logic        s_busy, s_rd_en, s_we, s_exc, s_diz, s_um, s_vm, s_ums, s_vms;
  logic [4:0]  s_sa, s_sb, s_idx, s_code;
  logic [31:0] s_addr, s_rdata, s_data;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: offset o of word w holds w[9:2] ^ {11,22,33,44}[o] (big endian)
  function automatic logic [31:0] mword(input logic [31:0] ad);
    return {ad[9:2] ^ 8'h11, ad[9:2] ^ 8'h22, ad[9:2] ^ 8'h33, ad[9:2] ^ 8'h44};
  endfunction

  assign f_rdata = mword(f_addr);
  assign s_rdata = mword(s_addr);

  bload_unit #(.AREA_OPT(1'b0), .REORDER_EN(1'b1), .BIG_ENDIAN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .cur_um(cur_um), .cur_vm(cur_vm),
    .xlat_miss(xlat_miss), .prot_viol(prot_viol), .busy(f_busy),
    .src_a_idx(f_sa), .src_b_idx(f_sb), .mem_rd_en(f_rd_en), .mem_addr(f_addr),
    .mem_rdata(f_rdata), .rd_we(f_we), .rd_idx(f_idx), .rd_data(f_data),
    .exc_valid(f_exc), .exc_code(f_code), .exc_diz_set(f_diz),
    .msr_um_nx(f_um), .msr_vm_nx(f_vm), .msr_ums_nx(f_ums), .msr_vms_nx(f_vms));

  bload_unit #(.AREA_OPT(1'b1), .REORDER_EN(1'b0), .BIG_ENDIAN(1'b1)) uut_area (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .cur_um(cur_um), .cur_vm(cur_vm),
    .xlat_miss(xlat_miss), .prot_viol(prot_viol), .busy(s_busy),
    .src_a_idx(s_sa), .src_b_idx(s_sb), .mem_rd_en(s_rd_en), .mem_addr(s_addr),
    .mem_rdata(s_rdata), .rd_we(s_we), .rd_idx(s_idx), .rd_data(s_data),
    .exc_valid(s_exc), .exc_code(s_code), .exc_diz_set(s_diz),
    .msr_um_nx(s_um), .msr_vm_nx(s_vm), .msr_ums_nx(s_ums), .msr_vms_nx(s_vms));

  function automatic string rname(input logic [3:0] n);
    case (n)
      4'd1: return "R1";   4'd2: return "R2";   4'd3: return "R3";
      4'd4: return "R4";   4'd5: return "R5";   4'd6: return "R6";
      4'd7: return "R7";   4'd8: return "R8";   4'd9: return "R9";
      4'd10: return "R10"; 4'd11: return "R11"; default: return "R12";
    endcase
  endfunction

  function automatic bit is_legal(input logic [31:0] w);
    return (w[31:26] == 6'b110000) && ((w[10:0] & 11'h5FF) == 11'd0);
  endfunction

  // {we, idx, data, exc, code, diz, um_nx, vm_nx, ums_nx, vms_nx}
  function automatic logic [48:0] expect_res(input vec_t v, input bit reo);
    logic [1:0] off;
    logic [7:0] k;
    logic [31:0] ea;
    if (!is_legal(v.instr)) return '0;
    if (v.vm && v.miss)
      return {1'b0, 5'd0, 32'd0, 1'b1, 5'b10010, 1'b0, 1'b0, 1'b0, v.um, v.vm};
    if (v.um && v.vm && v.prot)
      return {1'b0, 5'd0, 32'd0, 1'b1, 5'b10000, 1'b1, 1'b0, 1'b0, v.um, v.vm};
    ea  = v.a + v.b;
    off = ea[1:0];
    if (reo && v.instr[9]) off = 2'd3 - off;
    case (off)
      2'd0: k = 8'h11; 2'd1: k = 8'h22; 2'd2: k = 8'h33; default: k = 8'h44;
    endcase
    return {1'b1, v.instr[25:21], 24'd0, ea[9:2] ^ k, 1'b0, 5'd0, 1'b0, 4'd0};
  endfunction

  function automatic logic [48:0] fast_res();
    return {f_we, f_idx, f_data, f_exc, f_code, f_diz, f_um, f_vm, f_ums, f_vms};
  endfunction
  function automatic logic [48:0] area_res();
    return {s_we, s_idx, s_data, s_exc, s_code, s_diz, s_um, s_vm, s_ums, s_vms};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    issue_valid = 1'b1; instr = v.instr; opnd_a = v.a; opnd_b = v.b;
    cur_um = v.um; cur_vm = v.vm; xlat_miss = v.miss; prot_viol = v.prot;
  endtask

  task automatic idle();
    issue_valid = 1'b0; instr = '0; opnd_a = '0; opnd_b = '0;
    cur_um = 1'b0; cur_vm = 1'b0; xlat_miss = 1'b0; prot_viol = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R12 watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vec_t v0, v1;
    logic [48:0] e;
    bit ld;
    idle();
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(fast_res() == '0 && !f_busy, "R12", "fast in reset", 64'(fast_res()), 0);
    chk(area_res() == '0 && !s_busy, "R12", "area in reset", 64'(area_res()), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fast_res() == '0 && area_res() == '0 && !s_busy, "R12", "after release",
        64'(fast_res() | area_res()), 0);

    for (int i = 0; i < NVEC; i++) begin
      v0 = VEC[i];
      drive(v0);
      #1;
      e  = expect_res(v0, 1'b1);
      ld = e[48];
      // R2 / R9: combinational strobe and address of the speed build
      chk(f_rd_en == ld && (!ld || f_addr == v0.a + v0.b), rname(v0.req), "fast mem",
          {31'd0, f_rd_en, f_addr}, {31'd0, ld, v0.a + v0.b});
      chk(f_sa == v0.instr[20:16] && f_sb == v0.instr[15:11], "R1", "source idx",
          {f_sa, f_sb}, {v0.instr[20:16], v0.instr[15:11]});
      @(negedge clk);
      idle();
      // R10: speed build result one edge after issue
      chk(fast_res() == e, rname(v0.req), "fast result", 64'(fast_res()), 64'(e));
      // R11: stall flag in the cycle after acceptance
      chk(s_busy == is_legal(v0.instr), "R11", "busy", 64'(s_busy), 64'(is_legal(v0.instr)));
      @(negedge clk);
      e = expect_res(v0, 1'b0);
      chk(area_res() == e, rname(v0.req), "area result", 64'(area_res()), 64'(e));
    end

    // R10 / R11: back-to-back issue
    v0 = VEC[0];
    v1 = VEC[13];
    drive(v0);
    @(negedge clk);
    drive(v1);
    e = expect_res(v0, 1'b1);
    chk(fast_res() == e, "R10", "first of pair", 64'(fast_res()), 64'(e));
    chk(s_busy == 1'b1, "R11", "busy at second issue", 64'(s_busy), 1);
    @(negedge clk);
    idle();
    e = expect_res(v1, 1'b1);
    chk(fast_res() == e, "R10", "second of pair", 64'(fast_res()), 64'(e));
    e = expect_res(v0, 1'b0);
    chk(area_res() == e, "R11", "area first of pair", 64'(area_res()), 64'(e));
    @(negedge clk);
    chk(area_res() == '0 && !s_busy, "R11", "issue during busy ignored",
        64'(area_res()), 0);
    chk(fast_res() == '0, "R9", "idle clears results", 64'(fast_res()), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule